// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Control

This block is the receive-side control that sits behind a UART receiver core. The core reports each finished frame together with its data, and separately reports when the line has stayed idle for one whole frame time. This block decides whether each frame is handed to software. It drives a data-valid flag and holds the received byte. It can also place the receiver in a mute state, in which received frames are dropped without setting the flag.

Software can ask for mute, but hardware takes the receiver out of mute by itself when the chosen wakeup condition occurs. There are two wakeup methods. In idle-line mode, any idle-line report ends the mute. In address-mark mode, a received character with its top bit set carries a node address in its low bits, and wakeup happens when that address equals the configured node address. In address-mark mode, a mark for another node also puts an active receiver back into mute. Software writes to the mute bit are refused in two cases: in address-mark mode while unread data is pending, and in idle-line mode when mute is requested before any byte has been received.

All outputs are registered, so an event presented at a clock edge shows up at the outputs after that edge.

Top module: `uart_mute_wakeup`

## Requirements
- R1: After reset, `muted` is 0, `rxNotEmpty` is 0 and `rxData` is 0.
- R2: While `rxEnable` is 0, `frameValid` and `idleDetect` have no effect: `rxNotEmpty`, `rxData` and `muted` keep their values. Software mute writes still apply.
- R3: When the receiver is enabled and not muted, a frame that is not an address mark for another node sets `rxNotEmpty` and loads `rxData` one cycle later. A `dataRead` pulse clears `rxNotEmpty`. If a delivery and a read fall in the same cycle, the delivery wins.
- R4: A `muteWrite` pulse that is not locked (see R7, R10) and does not meet a hardware event (see R11) loads `muted` with `muteWriteValue` on the next cycle.
- R5: While muted, frames that do not wake the receiver leave `rxNotEmpty` and `rxData` unchanged.
- R6: With `wakeMethod` = 0 (idle-line), an enabled `idleDetect` while muted clears `muted`, and the next frame is delivered. With `wakeMethod` = 1, `idleDetect` has no effect on `muted`.
- R7: With `wakeMethod` = 0, a request to set mute is ignored until at least one frame has been received while enabled since reset. A request to clear mute is never ignored in this mode.
- R8: An address mark is a frame whose bit DATA_W-1 is 1. Its address is bits ADDR_W-1:0, compared with `nodeAddress`. With `wakeMethod` = 1, a matching mark clears `muted` and is delivered as in R3, whether the receiver was muted or not.
- R9: With `wakeMethod` = 1, a non-matching address mark sets `muted` and is not delivered.
- R10: With `wakeMethod` = 1, `muteWrite` is ignored while `rxNotEmpty` is 1.
- R11: When a hardware mute change falls in the same cycle as a software mute write, the hardware change wins. A hardware mute change is an address mark in mode 1, or an idle-line report while muted in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable |
| frameValid | input | 1 | One-cycle pulse: a frame was received |
| frameData | input | DATA_W | Data of the received frame |
| idleDetect | input | 1 | One-cycle pulse: idle line seen for a frame time |
| wakeMethod | input | 1 | 0 = idle-line wakeup, 1 = address-mark wakeup |
| nodeAddress | input | ADDR_W | This node's address |
| muteWrite | input | 1 | Software write strobe for the mute bit |
| muteWriteValue | input | 1 | Value written to the mute bit |
| dataRead | input | 1 | Software read strobe, clears the data-valid flag |
| muted | output | 1 | Mute status |
| rxNotEmpty | output | 1 | Received data is pending |
| rxData | output | DATA_W | Last delivered data |

## Verification
The bench feeds plain data frames, matching and non-matching address marks, and idle reports, first with the receiver enabled and then with it disabled. These patterns separate delivery from discard, and wakeup from re-mute. Mute writes are tried before and after the first byte and with data pending or not, which tells the two lock rules apart. Some events are placed in the same cycle: a delivery with a read, and an address mark or idle report with a mute write. These coincidences expose which side has priority.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

  typedef struct packed {
    logic deliver;  // load rxData and raise the data-valid flag
    logic consume;  // drop the data-valid flag
  } rxStrobes_t;

endpackage

// File: rtl/uart_mute_ctrl.sv
module uart_mute_ctrl
  import uart_mute_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       frameValid,
  input  logic       idleDetect,
  input  logic       wakeMethod,
  input  logic       muteWrite,
  input  logic       muteWriteValue,
  input  logic       dataRead,
  input  logic       isMark,
  input  logic       addrMatch,
  input  logic       flagSet,
  output logic       muted,
  output rxStrobes_t strobes
);

  logic gotByte;
  logic frameEv;
  logic idleEv;
  logic addrMode;
  logic markEv;
  logic idleWake;
  logic hwEvent;
  logic lockAddr;
  logic lockIdle;
  logic swApply;
  logic mutedNext;

  assign addrMode = wakeMethod;
  assign frameEv  = rxEnable & frameValid;
  assign idleEv   = rxEnable & idleDetect;
  assign markEv   = frameEv & addrMode & isMark;
  assign idleWake = idleEv & ~addrMode & muted;
  assign hwEvent  = markEv | idleWake;

  // software lock rules
  assign lockAddr = addrMode & flagSet;
  assign lockIdle = ~addrMode & muteWriteValue & ~gotByte;
  assign swApply  = muteWrite & ~hwEvent & ~lockAddr & ~lockIdle;

  always_comb begin
    mutedNext = muted;
    if (markEv) begin
      mutedNext = ~addrMatch;
    end else if (idleWake) begin
      mutedNext = 1'b0;
    end else if (swApply) begin
      mutedNext = muteWriteValue;
    end
  end

  always_comb begin
    strobes.deliver = 1'b0;
    if (frameEv) begin
      if (addrMode && isMark) begin
        strobes.deliver = addrMatch;
      end else begin
        strobes.deliver = ~muted;
      end
    end
    strobes.consume = dataRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muted   <= 1'b0;
      gotByte <= 1'b0;
    end else begin
      muted <= mutedNext;
      if (frameEv) begin
        gotByte <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_mute_datapath.sv
module uart_mute_datapath
  import uart_mute_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] frameData,
  input  logic [ADDR_W-1:0] nodeAddress,
  input  rxStrobes_t        strobes,
  output logic              isMark,
  output logic              addrMatch,
  output logic              rxNotEmpty,
  output logic [DATA_W-1:0] rxData
);

  localparam int MARK_BIT = DATA_W - 1;

  assign isMark    = frameData[MARK_BIT];
  assign addrMatch = (frameData[ADDR_W-1:0] == nodeAddress);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxNotEmpty <= 1'b0;
    end else begin
      if (strobes.deliver) begin
        rxData     <= frameData;
        rxNotEmpty <= 1'b1;
      end else if (strobes.consume) begin
        rxNotEmpty <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_mute_wakeup.sv
module uart_mute_wakeup
  import uart_mute_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              idleDetect,
  input  logic              wakeMethod,
  input  logic [ADDR_W-1:0] nodeAddress,
  input  logic              muteWrite,
  input  logic              muteWriteValue,
  input  logic              dataRead,
  output logic              muted,
  output logic              rxNotEmpty,
  output logic [DATA_W-1:0] rxData
);

  rxStrobes_t strobes;
  logic       isMark;
  logic       addrMatch;

  uart_mute_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .rxEnable       (rxEnable),
    .frameValid     (frameValid),
    .idleDetect     (idleDetect),
    .wakeMethod     (wakeMethod),
    .muteWrite      (muteWrite),
    .muteWriteValue (muteWriteValue),
    .dataRead       (dataRead),
    .isMark         (isMark),
    .addrMatch      (addrMatch),
    .flagSet        (rxNotEmpty),
    .muted          (muted),
    .strobes        (strobes)
  );

  uart_mute_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .frameData   (frameData),
    .nodeAddress (nodeAddress),
    .strobes     (strobes),
    .isMark      (isMark),
    .addrMatch   (addrMatch),
    .rxNotEmpty  (rxNotEmpty),
    .rxData      (rxData)
  );

endmodule

// File: rtl/uart_mute_wakeup_chk.sv
module uart_mute_wakeup_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              frameValid,
  input logic [DATA_W-1:0] frameData,
  input logic              idleDetect,
  input logic              wakeMethod,
  input logic [ADDR_W-1:0] nodeAddress,
  input logic              muteWrite,
  input logic              muteWriteValue,
  input logic              dataRead,
  input logic              muted,
  input logic              rxNotEmpty,
  input logic [DATA_W-1:0] rxData
);

  localparam int MARK_BIT = DATA_W - 1;

  logic markHit;
  logic markMiss;
  assign markHit  = rxEnable && frameValid && wakeMethod && frameData[MARK_BIT] &&
                    (frameData[ADDR_W-1:0] == nodeAddress);
  assign markMiss = rxEnable && frameValid && wakeMethod && frameData[MARK_BIT] &&
                    (frameData[ADDR_W-1:0] != nodeAddress);

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!muted && !rxNotEmpty && rxData == '0));

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !muteWrite) |=> ($stable(muted) && $stable(rxData)));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !(rxEnable && frameValid)) |=> !rxNotEmpty);

  p_sw_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (muteWrite && !muteWriteValue && !rxEnable && !wakeMethod) |=> !muted);

  p_muted_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (muted && rxEnable && frameValid && !wakeMethod) |=> ($stable(rxData) && !$rose(rxNotEmpty)));

  p_idle_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && idleDetect && !wakeMethod && muted) |=> !muted);

  p_mark_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    markHit |=> (!muted && rxNotEmpty && rxData == $past(frameData)));

  p_mark_mute_r9: assert property (@(posedge clk) disable iff (!rstN)
    (markMiss && !dataRead) |=> (muted && $stable(rxData) && $stable(rxNotEmpty)));

  p_addr_lock_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wakeMethod && rxNotEmpty && muteWrite && !(rxEnable && frameValid)) |=> $stable(muted));

endmodule

bind uart_mute_wakeup uart_mute_wakeup_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/uart_mute_wakeup_tb.sv
`timescale 1ns/1ps
module uart_mute_wakeup_tb;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef struct {
    logic              muted;
    logic              rxne;
    logic [DATA_W-1:0] data;
    string             tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rxEnable = 1'b0;
  logic              frameValid = 1'b0;
  logic [DATA_W-1:0] frameData = '0;
  logic              idleDetect = 1'b0;
  logic              wakeMethod = 1'b0;
  logic [ADDR_W-1:0] nodeAddress = 4'hA;
  logic              muteWrite = 1'b0;
  logic              muteWriteValue = 1'b0;
  logic              dataRead = 1'b0;
  logic              muted;
  logic              rxNotEmpty;
  logic [DATA_W-1:0] rxData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  expItem_t expQ[$];

  // reference model state
  logic              mMuted = 1'b0;
  logic              mRxne = 1'b0;
  logic [DATA_W-1:0] mData = '0;
  logic              mGot = 1'b0;

  always #4 clk = ~clk;

  uart_mute_wakeup #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameValid(frameValid),
    .frameData(frameData), .idleDetect(idleDetect), .wakeMethod(wakeMethod),
    .nodeAddress(nodeAddress), .muteWrite(muteWrite), .muteWriteValue(muteWriteValue),
    .dataRead(dataRead), .muted(muted), .rxNotEmpty(rxNotEmpty), .rxData(rxData)
  );

  // monitor: compare outputs shortly after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (muted !== e.muted || rxNotEmpty !== e.rxne || rxData !== e.data) begin
        fails++;
        $display("FAIL %s: got muted=%0b rxne=%0b data=%h, expected muted=%0b rxne=%0b data=%h",
                 e.tag, muted, rxNotEmpty, rxData, e.muted, e.rxne, e.data);
      end
    end
  end

  // driver: one cycle of stimulus plus the expected result after the edge
  task automatic step(input logic en, input logic fv, input logic [DATA_W-1:0] d,
                      input logic idl, input logic wm, input logic mw, input logic mwv,
                      input logic rd, input string tag);
    logic frameEv, idleEv, isMark, match, hw, deliver, nMuted;
    expItem_t e;
    @(negedge clk);
    rxEnable = en; frameValid = fv; frameData = d; idleDetect = idl;
    wakeMethod = wm; muteWrite = mw; muteWriteValue = mwv; dataRead = rd;
    frameEv = en & fv;
    idleEv  = en & idl;
    isMark  = d[DATA_W-1];
    match   = (d[ADDR_W-1:0] == nodeAddress);
    hw      = (frameEv & wm & isMark) | (idleEv & ~wm & mMuted);
    deliver = 1'b0;
    nMuted  = mMuted;
    if (frameEv) begin
      if (wm && isMark) begin
        nMuted  = ~match;
        deliver = match;
      end else begin
        deliver = ~mMuted;
      end
    end
    if (idleEv && !wm && mMuted) nMuted = 1'b0;
    if (mw && !hw && !(wm && mRxne) && !(!wm && mwv && !mGot)) nMuted = mwv;
    if (deliver) begin
      mRxne = 1'b1;
      mData = d;
    end else if (rd) begin
      mRxne = 1'b0;
    end
    if (frameEv) mGot = 1'b1;
    mMuted = nMuted;
    e.muted = mMuted; e.rxne = mRxne; e.data = mData; e.tag = tag;
    expQ.push_back(e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    step(1, 0, 8'h00, 0, 0, 0, 0, 0, "R1 reset");
    // R7 mute request before any byte ignored (idle mode)
    step(1, 0, 8'h00, 0, 0, 1, 1, 0, "R7 early mute");
    // R2 disabled: frame ignored
    step(0, 1, 8'h5C, 0, 0, 0, 0, 0, "R2 disabled frame");
    // R3 delivery, read, delivery beating read
    step(1, 1, 8'h35, 0, 0, 0, 0, 0, "R3 deliver");
    step(1, 0, 8'h00, 0, 0, 0, 0, 1, "R3 read");
    step(1, 1, 8'h47, 0, 0, 0, 0, 1, "R3 deliver vs read");
    step(1, 0, 8'h00, 0, 0, 0, 0, 1, "R3 read2");
    // R4 mute now accepted
    step(1, 0, 8'h00, 0, 0, 1, 1, 0, "R4 R7 mute after byte");
    // R5 muted frame dropped
    step(1, 1, 8'h66, 0, 0, 0, 0, 0, "R5 muted drop");
    // R2 disabled idle does not wake
    step(0, 0, 8'h00, 1, 0, 0, 0, 0, "R2 disabled idle");
    // R6 idle wakes, next frame delivered
    step(1, 0, 8'h00, 1, 0, 0, 0, 0, "R6 idle wake");
    step(1, 1, 8'h21, 0, 0, 0, 0, 0, "R6 deliver after wake");
    step(1, 0, 8'h00, 0, 0, 0, 0, 1, "R3 read3");
    // R4 software clear
    step(1, 0, 8'h00, 0, 0, 1, 1, 0, "R4 mute");
    step(0, 0, 8'h00, 0, 0, 1, 0, 0, "R4 R2 clear while disabled");
    // R11 idle mode: idle wake beats mute write
    step(1, 0, 8'h00, 0, 0, 1, 1, 0, "R4 mute again");
    step(1, 0, 8'h00, 1, 0, 1, 1, 0, "R11 idle vs write");
    // address mode
    step(1, 1, 8'h12, 0, 1, 0, 0, 0, "R3 addr mode data");
    step(1, 0, 8'h00, 0, 1, 1, 1, 0, "R10 write locked by rxne");
    step(1, 0, 8'h00, 0, 1, 0, 0, 1, "R3 read4");
    step(1, 0, 8'h00, 0, 1, 1, 1, 0, "R4 mute addr mode");
    step(1, 1, 8'h33, 0, 1, 0, 0, 0, "R5 muted data drop");
    step(1, 1, 8'h83, 0, 1, 0, 0, 0, "R5 R9 muted wrong mark");
    step(1, 0, 8'h00, 1, 1, 0, 0, 0, "R6 idle ignored addr mode");
    step(1, 1, 8'h8A, 0, 1, 0, 0, 0, "R8 matching mark wakes");
    step(1, 1, 8'h55, 0, 1, 0, 0, 1, "R8 R3 data after wake");
    step(1, 0, 8'h00, 0, 1, 0, 0, 1, "R3 read5");
    step(1, 1, 8'hF3, 0, 1, 0, 0, 0, "R9 wrong mark mutes");
    step(1, 1, 8'hDA, 0, 1, 1, 1, 0, "R11 R8 mark vs write");
    step(1, 0, 8'h00, 0, 1, 1, 0, 0, "R10 clear locked by rxne");
    step(1, 0, 8'h00, 0, 1, 0, 0, 1, "R3 read6");
    step(1, 1, 8'h9A, 0, 1, 1, 0, 0, "R8 R11 active match");
    step(1, 0, 8'h00, 0, 1, 0, 0, 0, "R8 settle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule